// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block sits between a 16-bit microcontroller bus and the on-chip memories and registers. For every bus access it produces exactly one resource select, or none. It captures the bus address, either from shared address/data lines under an address strobe or from a separate address bus. It then places an 8-bit page value above that address, which gives a 24-bit address space. That space is decoded into selects for 16 primary flash sectors, 4 secondary flash sectors, one SRAM and a 256-byte register window.

The register window holds two registers. The page register sits at offset 0xE0. The space register sits at offset 0xE2 and decides, for each memory, whether it answers program fetches, data accesses or both. A swap bit in the space register takes the secondary flash out of the map. A chip-select input turns off the memories but leaves the register window reachable. The block also drives the read-data bus, but only during a read that selected something.

Each memory window is set by a base and mask parameter pair. The register window matches the upper byte of the unpaged bus address. Selects and the read-drive enable are registered: they appear on the clock edge at which the access strobe is sampled.

Top module: `paged_mmap_decoder`

## Requirements
- R1: With LATCH_MODE=1, the address register follows `ad_in` on every clock edge at which `ale` is high and holds while `ale` is low.
- R2: With LATCH_MODE=2, the address is captured only at the edge where `ale` is high after being low on the previous edge. Further edges with `ale` still high do not change it.
- R3: The decoded address is {page, bus address}. A write to register offset 0xE0 loads the page from write-data bits 7:0 and a read returns it. Writes to other offsets leave the page unchanged.
- R4: A primary flash hit selects `pri_sel[k]`, where k is the 4-bit address field starting at PRI_SECT_LSB.
- R5: A secondary flash hit selects `sec_sel[k]`, where k is the 2-bit address field starting at SEC_SECT_LSB.
- R6: Priority from highest to lowest is register window, SRAM, secondary flash, primary flash. A window whose memory is not enabled for the access type passes the access on to the next lower window. At most one select is high.
- R7: Space register at offset 0xE2. The bits are: 0 primary program, 1 primary data, 2 secondary program, 3 secondary data, 4 SRAM program, 5 SRAM data, 7 swap. Bit 6 always reads 0. A program fetch (`prog_strb`) selects a memory only if its program bit is set. A read or write selects a memory only if its data bit is set.
- R8: While swap (space bit 7) is 1, no `sec_sel` bit is ever asserted.
- R9: While `csi_n` is high, no memory select is asserted, but register window accesses still select `reg_sel`.
- R10: `drive_en` is high only for a read that selected a resource. `rd_bus` then carries the register value, or `mem_rdata` for a memory. Otherwise `rd_bus` is high impedance.
- R11: While `rst_n` is low at a clock edge, the page clears to 0x00, the space register becomes 0x3F and all selects and `drive_en` go low.
- R12: The register window matches bus address bits 15:8 against REG_BASE whatever the page. It answers reads and writes but not program fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ale | input | 1 | Address strobe |
| ad_in | input | 16 | Address, or multiplexed address/data |
| data_in | input | 16 | Write data in non-multiplexed mode |
| prog_strb | input | 1 | Program fetch strobe, active high |
| rd_strb | input | 1 | Data read strobe, active high |
| wr_strb | input | 1 | Data write strobe, active high |
| csi_n | input | 1 | Chip select input; high disables memories |
| mem_rdata | input | 16 | Read data from the selected memory |
| pri_sel | output | 16 | Primary flash sector selects |
| sec_sel | output | 4 | Secondary flash sector selects |
| ram_sel | output | 1 | SRAM select |
| reg_sel | output | 1 | Register window select |
| drive_en | output | 1 | Read bus drive enable |
| rd_bus | output | 16 | Read data bus, high impedance when idle |

## Verification
The bench builds two copies of the block with identical windows, one with LATCH_MODE=1 and one with LATCH_MODE=2. The primary window is 2 MB wide, so all 16 sectors are indexed by page bits. The secondary window sits inside the primary window, the SRAM window sits inside the secondary window, and REG_BASE is 0x10. These overlaps put every priority case within reach of a full sweep of all 256 pages. Several space register values, including swap, and `csi_n` high are then swept over both fetch types. A held strobe lets the two copies be compared, to separate level capture from edge capture.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PROG = 2'd1,
    ACC_DATA = 2'd2
  } acc_e;

  localparam int SP_PRI_PROG = 0;
  localparam int SP_PRI_DATA = 1;
  localparam int SP_SEC_PROG = 2;
  localparam int SP_SEC_DATA = 3;
  localparam int SP_RAM_PROG = 4;
  localparam int SP_RAM_DATA = 5;
  localparam int SP_SWAP     = 7;

  localparam logic [7:0] SPACE_RESET = 8'h3F;
  localparam logic [7:0] SPACE_WMASK = 8'hBF;
  localparam logic [7:0] OFS_PAGE    = 8'hE0;
  localparam logic [7:0] OFS_SPACE   = 8'hE2;

endpackage

// File: rtl/mmap_addr_latch.sv
module mmap_addr_latch #(
  parameter int BUS_W      = 16,
  parameter int LATCH_MODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] addr_q
);

  logic ale_prev;
  logic take;

  always_ff @(posedge clk) begin
    if (!rst_n) ale_prev <= 1'b0;
    else        ale_prev <= ale;
  end

  generate
    if (LATCH_MODE == 0) begin : g_direct
      assign take = 1'b1;
    end else if (LATCH_MODE == 1) begin : g_level
      assign take = ale;
    end else begin : g_edge
      assign take = ale & ~ale_prev;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (take) addr_q <= ad_in;
  end

  generate
    if (LATCH_MODE != 0) begin : g_chk
      AST_ADDR_ONLY_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> $past(ale)) else $error("address moved without strobe"); // R1
    end
    if (LATCH_MODE == 2) begin : g_chk_edge
      AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ale) && $past(ale_prev)) |-> $stable(addr_q)) else $error("edge capture moved"); // R2
    end
  endgenerate

endmodule

// File: rtl/mmap_ctrl_regs.sv
module mmap_ctrl_regs
  import mmap_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_page,
  input  logic              wr_space,
  input  logic [7:0]        wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic [7:0]        space_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      space_q <= SPACE_RESET;
    end else begin
      if (wr_page)  page_q  <= wdata[PAGE_W-1:0];
      if (wr_space) space_q <= wdata & SPACE_WMASK;
    end
  end

  AST_RESET_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (page_q == '0 && space_q == SPACE_RESET)) else $error("reset values"); // R11
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_page) |-> $stable(page_q)) else $error("page moved without write"); // R3

endmodule

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
#(
  parameter int BUS_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int PRI_N   = 16,
  parameter int SEC_N   = 4,
  parameter logic [PAGE_W+BUS_W-1:0] PRI_BASE = '0,
  parameter logic [PAGE_W+BUS_W-1:0] PRI_MASK = '0,
  parameter int PRI_SECT_LSB = 16,
  parameter logic [PAGE_W+BUS_W-1:0] SEC_BASE = '0,
  parameter logic [PAGE_W+BUS_W-1:0] SEC_MASK = '0,
  parameter int SEC_SECT_LSB = 14,
  parameter logic [PAGE_W+BUS_W-1:0] RAM_BASE = '0,
  parameter logic [PAGE_W+BUS_W-1:0] RAM_MASK = '0,
  parameter logic [7:0] REG_BASE = 8'h00
) (
  input  logic [PAGE_W+BUS_W-1:0] full_addr,
  input  acc_e                    acc,
  input  logic [7:0]              space,
  input  logic                    csi_n,
  output logic [PRI_N-1:0]        pri_sel,
  output logic [SEC_N-1:0]        sec_sel,
  output logic                    ram_sel,
  output logic                    reg_sel
);

  localparam int PRI_IW = $clog2(PRI_N);
  localparam int SEC_IW = $clog2(SEC_N);

  logic is_prog, is_data, mem_ok;
  logic pri_en, sec_en, ram_en;
  logic pri_hit, sec_hit, ram_hit, reg_hit;
  logic pri_take, sec_take;
  logic [PRI_IW-1:0] pri_idx;
  logic [SEC_IW-1:0] sec_idx;
  logic unused_bits;

  assign unused_bits = space[6];

  assign is_prog = (acc == ACC_PROG);
  assign is_data = (acc == ACC_DATA);
  assign mem_ok  = ~csi_n;

  assign pri_en = (is_prog & space[SP_PRI_PROG]) | (is_data & space[SP_PRI_DATA]);
  assign sec_en = ((is_prog & space[SP_SEC_PROG]) | (is_data & space[SP_SEC_DATA]))
                  & ~space[SP_SWAP];
  assign ram_en = (is_prog & space[SP_RAM_PROG]) | (is_data & space[SP_RAM_DATA]);

  assign reg_hit = is_data && (full_addr[BUS_W-1 -: 8] == REG_BASE);
  assign ram_hit = mem_ok && ram_en && ((full_addr & RAM_MASK) == RAM_BASE);
  assign sec_hit = mem_ok && sec_en && ((full_addr & SEC_MASK) == SEC_BASE);
  assign pri_hit = mem_ok && pri_en && ((full_addr & PRI_MASK) == PRI_BASE);

  assign reg_sel  = reg_hit;
  assign ram_sel  = ram_hit & ~reg_hit;
  assign sec_take = sec_hit & ~reg_hit & ~ram_hit;
  assign pri_take = pri_hit & ~reg_hit & ~ram_hit & ~sec_hit;

  assign pri_idx = full_addr[PRI_SECT_LSB +: PRI_IW];
  assign sec_idx = full_addr[SEC_SECT_LSB +: SEC_IW];

  generate
    for (genvar i = 0; i < PRI_N; i++) begin : g_pri
      assign pri_sel[i] = pri_take && (pri_idx == PRI_IW'(i));
    end
    for (genvar j = 0; j < SEC_N; j++) begin : g_sec
      assign sec_sel[j] = sec_take && (sec_idx == SEC_IW'(j));
    end
  endgenerate

endmodule

// File: rtl/paged_mmap_decoder.sv
module paged_mmap_decoder
  import mmap_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int PAGE_W     = 8,
  parameter int PRI_N      = 16,
  parameter int SEC_N      = 4,
  parameter int LATCH_MODE = 1,
  parameter logic [PAGE_W+BUS_W-1:0] PRI_BASE = 24'h000000,
  parameter logic [PAGE_W+BUS_W-1:0] PRI_MASK = 24'hF00000,
  parameter int PRI_SECT_LSB = 16,
  parameter logic [PAGE_W+BUS_W-1:0] SEC_BASE = 24'h100000,
  parameter logic [PAGE_W+BUS_W-1:0] SEC_MASK = 24'hFF0000,
  parameter int SEC_SECT_LSB = 14,
  parameter logic [PAGE_W+BUS_W-1:0] RAM_BASE = 24'h110000,
  parameter logic [PAGE_W+BUS_W-1:0] RAM_MASK = 24'hFF8000,
  parameter logic [7:0] REG_BASE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic [BUS_W-1:0] ad_in,
  input  logic [BUS_W-1:0] data_in,
  input  logic             prog_strb,
  input  logic             rd_strb,
  input  logic             wr_strb,
  input  logic             csi_n,
  input  logic [BUS_W-1:0] mem_rdata,
  output logic [PRI_N-1:0] pri_sel,
  output logic [SEC_N-1:0] sec_sel,
  output logic             ram_sel,
  output logic             reg_sel,
  output logic             drive_en,
  output logic [BUS_W-1:0] rd_bus
);

  localparam int FULL_W = PAGE_W + BUS_W;

  logic [BUS_W-1:0]  addr_q;
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        space_q;
  logic [7:0]        wdata;
  logic [7:0]        offset;
  acc_e              acc;
  logic [PRI_N-1:0]  pri_c;
  logic [SEC_N-1:0]  sec_c;
  logic              ram_c, reg_c;
  logic              wr_page, wr_space;
  logic [7:0]        reg_rd_q;
  logic              unused_hi;

  mmap_addr_latch #(.BUS_W(BUS_W), .LATCH_MODE(LATCH_MODE)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .addr_q(addr_q)
  );

  assign wdata     = (LATCH_MODE == 0) ? data_in[7:0] : ad_in[7:0];
  assign unused_hi = ^{data_in[BUS_W-1:8], (LATCH_MODE == 0) ? 1'b0 : data_in[0]};
  assign offset    = addr_q[7:0];

  always_comb begin
    if (prog_strb)               acc = ACC_PROG;
    else if (rd_strb || wr_strb) acc = ACC_DATA;
    else                         acc = ACC_NONE;
  end

  mmap_decode #(
    .BUS_W(BUS_W), .PAGE_W(PAGE_W), .PRI_N(PRI_N), .SEC_N(SEC_N),
    .PRI_BASE(PRI_BASE), .PRI_MASK(PRI_MASK), .PRI_SECT_LSB(PRI_SECT_LSB),
    .SEC_BASE(SEC_BASE), .SEC_MASK(SEC_MASK), .SEC_SECT_LSB(SEC_SECT_LSB),
    .RAM_BASE(RAM_BASE), .RAM_MASK(RAM_MASK), .REG_BASE(REG_BASE)
  ) u_decode (
    .full_addr({page_q, addr_q}), .acc(acc), .space(space_q), .csi_n(csi_n),
    .pri_sel(pri_c), .sec_sel(sec_c), .ram_sel(ram_c), .reg_sel(reg_c)
  );

  assign wr_page  = wr_strb && !prog_strb && reg_c && (offset == OFS_PAGE);
  assign wr_space = wr_strb && !prog_strb && reg_c && (offset == OFS_SPACE);

  mmap_ctrl_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_page(wr_page), .wr_space(wr_space),
    .wdata(wdata), .page_q(page_q), .space_q(space_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_sel  <= '0;
      sec_sel  <= '0;
      ram_sel  <= 1'b0;
      reg_sel  <= 1'b0;
      drive_en <= 1'b0;
      reg_rd_q <= '0;
    end else begin
      pri_sel  <= pri_c;
      sec_sel  <= sec_c;
      ram_sel  <= ram_c;
      reg_sel  <= reg_c;
      drive_en <= rd_strb && !prog_strb && (|{pri_c, sec_c, ram_c, reg_c});
      if (offset == OFS_PAGE)       reg_rd_q <= 8'(page_q);
      else if (offset == OFS_SPACE) reg_rd_q <= space_q;
      else                          reg_rd_q <= '0;
    end
  end

  assign rd_bus = drive_en ? (reg_sel ? {{(BUS_W-8){1'b0}}, reg_rd_q} : mem_rdata)
                           : {BUS_W{1'bz}};

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pri_sel, sec_sel, ram_sel, reg_sel})) else $error("multiple selects"); // R6
  AST_SWAP_HIDES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (|sec_sel) |-> !$past(space_q[SP_SWAP])) else $error("secondary while swapped"); // R8
  AST_CSI_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csi_n) |-> !(|{pri_sel, sec_sel, ram_sel})) else $error("memory with csi high"); // R9
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> $past(rd_strb)) else $error("drive without read"); // R10
  AST_RAM_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> ($past(prog_strb) ? $past(space_q[SP_RAM_PROG]) : $past(space_q[SP_RAM_DATA])))
    else $error("sram outside its space"); // R7
  AST_REG_NOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> !$past(prog_strb)) else $error("register window on fetch"); // R12

endmodule

// File: tb/tb_paged_mmap_decoder.sv
`timescale 1ns/1ps
module tb_paged_mmap_decoder;

  localparam logic [23:0] P_PRI_BASE = 24'h000000;
  localparam logic [23:0] P_PRI_MASK = 24'hE00000;
  localparam logic [23:0] P_SEC_BASE = 24'h100000;
  localparam logic [23:0] P_SEC_MASK = 24'hFF0000;
  localparam logic [23:0] P_RAM_BASE = 24'h108000;
  localparam logic [23:0] P_RAM_MASK = 24'hFF8000;
  localparam logic [15:0] MEMDATA    = 16'hA5C3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ale, prog_strb, rd_strb, wr_strb, csi_n;
  logic [15:0] ad_in, data_in, mem_rdata;
  logic [15:0] pri_a, pri_b;
  logic [3:0]  sec_a, sec_b;
  logic ram_a, ram_b, reg_a, reg_b, drv_a, drv_b;
  logic [15:0] bus_a, bus_b;

  paged_mmap_decoder #(
    .LATCH_MODE(1), .PRI_BASE(P_PRI_BASE), .PRI_MASK(P_PRI_MASK), .PRI_SECT_LSB(17),
    .SEC_BASE(P_SEC_BASE), .SEC_MASK(P_SEC_MASK), .SEC_SECT_LSB(14),
    .RAM_BASE(P_RAM_BASE), .RAM_MASK(P_RAM_MASK), .REG_BASE(8'h10)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .data_in(data_in),
    .prog_strb(prog_strb), .rd_strb(rd_strb), .wr_strb(wr_strb), .csi_n(csi_n),
    .mem_rdata(mem_rdata), .pri_sel(pri_a), .sec_sel(sec_a), .ram_sel(ram_a),
    .reg_sel(reg_a), .drive_en(drv_a), .rd_bus(bus_a)
  );

  paged_mmap_decoder #(
    .LATCH_MODE(2), .PRI_BASE(P_PRI_BASE), .PRI_MASK(P_PRI_MASK), .PRI_SECT_LSB(17),
    .SEC_BASE(P_SEC_BASE), .SEC_MASK(P_SEC_MASK), .SEC_SECT_LSB(14),
    .RAM_BASE(P_RAM_BASE), .RAM_MASK(P_RAM_MASK), .REG_BASE(8'h10)
  ) dut_edge (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .data_in(data_in),
    .prog_strb(prog_strb), .rd_strb(rd_strb), .wr_strb(wr_strb), .csi_n(csi_n),
    .mem_rdata(mem_rdata), .pri_sel(pri_b), .sec_sel(sec_b), .ram_sel(ram_b),
    .reg_sel(reg_b), .drive_en(drv_b), .rd_bus(bus_b)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] page_m, space_m;
  logic [21:0] g_sel_a, g_sel_b;
  logic g_drv_a, g_drv_b;
  logic [15:0] g_bus_a;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // layout {reg, ram, sec[3:0], pri[15:0]}
  function automatic logic [21:0] model_sel(input logic [7:0] pg, input logic [15:0] a,
                                            input int kind, input logic [7:0] sp,
                                            input logic cs_n);
    logic [23:0] f;
    logic pe, se, re;
    logic [21:0] r;
    f = {pg, a};
    r = '0;
    if (kind != 2 && a[15:8] == 8'h10) r[21] = 1'b1;
    else if (!cs_n) begin
      pe = (kind == 2) ? sp[0] : sp[1];
      se = (kind == 2) ? sp[2] : sp[3];
      re = (kind == 2) ? sp[4] : sp[5];
      if (((f & P_RAM_MASK) == P_RAM_BASE) && re) r[20] = 1'b1;
      else if (((f & P_SEC_MASK) == P_SEC_BASE) && se && !sp[7]) r[16 + int'(a[15:14])] = 1'b1;
      else if (((f & P_PRI_MASK) == P_PRI_BASE) && pe) r[int'(f[20:17])] = 1'b1;
    end
    return r;
  endfunction

  task automatic sample();
    g_sel_a = {reg_a, ram_a, sec_a, pri_a};
    g_sel_b = {reg_b, ram_b, sec_b, pri_b};
    g_drv_a = drv_a;
    g_drv_b = drv_b;
    g_bus_a = bus_a;
  endtask

  // kind: 0 read, 1 write, 2 program fetch
  task automatic do_access(input logic [15:0] addr, input int kind, input logic [7:0] wd);
    @(negedge clk);
    ale = 1'b1; ad_in = addr;
    @(negedge clk);
    ale = 1'b0; ad_in = {8'h00, wd}; data_in = {8'h00, wd};
    rd_strb = (kind == 0); wr_strb = (kind == 1); prog_strb = (kind == 2);
    @(negedge clk);
    sample();
    rd_strb = 1'b0; wr_strb = 1'b0; prog_strb = 1'b0;
  endtask

  task automatic check_access(input string req, input logic [15:0] addr, input int kind,
                              input logic [7:0] wd);
    logic [21:0] e;
    logic ed;
    logic [15:0] eb;
    e  = model_sel(page_m, addr, kind, space_m, csi_n);
    ed = (kind == 0) && (e != '0);
    if (addr[7:0] == 8'hE0)      eb = {8'h00, page_m};
    else if (addr[7:0] == 8'hE2) eb = {8'h00, space_m};
    else                         eb = 16'h0000;
    if (!e[21]) eb = MEMDATA;
    do_access(addr, kind, wd);
    chk(req, 32'(g_sel_a), 32'(e));
    chk(req, 32'(g_sel_b), 32'(e));
    chk({req, " R10 drive"}, 32'({g_drv_a, g_drv_b}), 32'({ed, ed}));
    if (ed) chk({req, " R10 data"}, 32'(g_bus_a), 32'(eb));
    if (kind == 1 && e[21]) begin
      if (addr[7:0] == 8'hE0) page_m = wd;
      if (addr[7:0] == 8'hE2) space_m = wd & 8'hBF;
    end
  endtask

  task automatic set_page(input logic [7:0] p);
    check_access("R3 page write", 16'h10E0, 1, p);
  endtask

  task automatic set_space(input logic [7:0] s);
    check_access("R7 space write", 16'h10E2, 1, s);
  endtask

  task automatic sweep(input string req, input int pstep, input bit both_kinds);
    logic [7:0] his [5] = '{8'h00, 8'h10, 8'h40, 8'h80, 8'hC0};
    for (int p = 0; p < 256; p += pstep) begin
      set_page(8'(p));
      for (int h = 0; h < 5; h++) begin
        check_access(req, {his[h], 8'h34}, 0, 8'h00);
        if (both_kinds) check_access(req, {his[h], 8'h34}, 2, 8'h00);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ale = 1'b0; prog_strb = 1'b0; rd_strb = 1'b0; wr_strb = 1'b0;
    csi_n = 1'b0; ad_in = '0; data_in = '0; mem_rdata = MEMDATA;
    page_m = 8'h00; space_m = 8'h3F;
    repeat (4) @(negedge clk);
    sample();
    chk("R11 selects in reset", 32'({g_sel_a, g_drv_a}), 32'h0);
    chk("R11 selects in reset edge", 32'({g_sel_b, g_drv_b}), 32'h0);
    rst_n = 1'b1;

    // R11 register defaults read back
    check_access("R11 page default", 16'h10E0, 0, 8'h00);
    check_access("R11 space default", 16'h10E2, 0, 8'h00);

    // R3 write and read page, other offset ignored
    set_page(8'h55);
    check_access("R3 page readback", 16'h10E0, 0, 8'h00);
    check_access("R3 other offset write", 16'h10E1, 1, 8'h77);
    check_access("R3 page unchanged", 16'h10E0, 0, 8'h00);

    // R12 register window ignores page, skips fetches
    set_page(8'hC3);
    check_access("R12 window under page", 16'h10E0, 0, 8'h00);
    check_access("R12 fetch at window", 16'h10E0, 2, 8'h00);
    set_page(8'h10);
    check_access("R12 fetch falls to memory", 16'h10E0, 2, 8'h00);

    // R4 R5 R6 full page sweep with default space
    sweep("R4 R5 R6 sweep", 1, 1'b0);

    // R7 space variants, R8 swap
    set_space(8'h15); sweep("R7 program only", 8, 1'b1);
    set_space(8'h2A); sweep("R7 data only", 8, 1'b1);
    set_space(8'h00); sweep("R7 none", 8, 1'b1);
    set_space(8'h19); sweep("R7 mixed", 8, 1'b1);
    set_space(8'hFF);
    check_access("R7 bit6 reads zero", 16'h10E2, 0, 8'h00);
    sweep("R8 swap", 8, 1'b1);
    set_space(8'h3F);

    // R9 chip select high
    csi_n = 1'b1;
    sweep("R9 csi high", 8, 1'b1);
    check_access("R9 window with csi high", 16'h10E2, 0, 8'h00);
    csi_n = 1'b0;

    // R1 R2 held strobe: level takes last address, edge takes first
    set_page(8'h10);
    @(negedge clk); ale = 1'b1; ad_in = 16'h0000;
    @(negedge clk); ad_in = 16'h4000;
    @(negedge clk); ale = 1'b0; ad_in = 16'h0000; rd_strb = 1'b1;
    @(negedge clk); sample(); rd_strb = 1'b0;
    chk("R1 level capture", 32'(g_sel_a), 32'(22'h1 << 17));
    chk("R2 edge capture", 32'(g_sel_b), 32'(22'h1 << 16));

    // R1 hold: data phase must not move the address
    check_access("R1 hold after strobe", 16'h8034, 0, 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule